// File: doc/BRIEF.md
# Linked Command Packet DMA Walker

This block walks a chain of command packets held in word-addressed memory and streams each packet's payload words, in order, to a single command sink. Each packet opens with a header word that gives how many payload words follow it and where the next header lives. The engine loads a base address on a start pulse and reads the header at that address. It then fetches the payload words one at a time through a memory read port and hands each to the sink. It follows the links until it meets the terminator address.

Packets with a zero count are passed over without touching the sink. After one or more skips, the engine records the first non-empty header it finds in its base register and ends that step without sending anything. It then reactivates itself from the base register to send the packet. Because the base register always holds the point from which the walk continues, a walk can be resumed. `busy` covers the whole walk, and a one-cycle `done` pulse marks its end. That pulse is meant to drive the channel-completion input of an interrupt block.

Top module: `cmd_chain_dma`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req_valid` and `sink_valid` are low and `base_addr` is zero.
- R2: A `start` pulse taken in idle loads `base_addr` with `start_addr` unchanged and starts the walk. The first memory read goes to `start_addr` with bits 1:0 cleared.
- R3: A header word carries the payload count in bits 31:24 and the next-header address in bits 23:0. A next address is used with bits 1:0 cleared.
- R4: For a header at address H with count N > 0 reached directly from the base register, words H+4, H+8 … H+4N are read and sent to the sink in that order, each exactly once.
- R5: After the last word of a packet is accepted, `base_addr` takes the header's next field. If that field is 0xFFFFFF the walk ends; otherwise the engine reads the header at that address next.
- R6: A zero-count header whose next field is not 0xFFFFFF is passed over by following its link, and nothing is sent to the sink for it.
- R7: When a non-zero header is reached after one or more skips, `base_addr` takes that header's address and nothing is sent in that step. The engine then rereads the header from `base_addr` and sends its packet.
- R8: A zero-count header whose next field is 0xFFFFFF ends the walk with `base_addr` = 0xFFFFFF and nothing sent.
- R9: `busy` is high from the cycle after the accepted `start` until the walk ends. `done` is then high for exactly one cycle, with `busy` low and `base_addr` = 0xFFFFFF.
- R10: While the sink or the memory holds off its ready, the engine keeps its valid and its data or address stable. No word is dropped or duplicated.
- R11: `start` is ignored while `busy` is high.
- R12: Every memory request address is word aligned (bits 1:0 zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk from `start_addr` (taken only when idle) |
| start_addr | input | 24 | Initial base address |
| base_addr | output | 24 | Base register, resume point of the walk |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_addr | output | 24 | Memory read byte address, word aligned |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| sink_valid | output | 1 | Command word valid |
| sink_data | output | 32 | Command word |
| sink_ready | input | 1 | Sink accepts the word |

## Verification
The bench sweeps single-packet chains over a range of counts, with the sink and memory always ready and then with irregular back-pressure. An off-by-one in the word counter would show up as one word too few or too many. A stall bug would show up as a repeated or missing word. Chains that open with empty headers, empty headers that end in the terminator, and misaligned start and link addresses check that skipped packets never reach the sink. They also check that the base register records the yield point before the packet is sent and that masked addresses are the only ones issued. A start pulse arriving mid-walk must leave the word stream and base-register trace unchanged; a design that restarted on it would repeat packets.

// File: rtl/cmd_chain_pkg.sv
// Shared types of the linked command packet walker.
package cmd_chain_pkg;
    // Walker control states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR_REQ,
        ST_HDR_WAIT,
        ST_PAY_REQ,
        ST_PAY_WAIT,
        ST_PAY_PUSH,
        ST_YIELD,
        ST_FINISH
    } walk_state_t;
endpackage

// File: rtl/cmd_chain_hdr.sv
// Header word decoder.
// Splits a header into its payload count (upper bits) and next-header
// address (lower ADDR_W bits) and flags the empty and terminator cases.
// Assumes DATA_W > ADDR_W.
module cmd_chain_hdr #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]        word,
    output logic [DATA_W-ADDR_W-1:0] count,
    output logic [ADDR_W-1:0]        next_addr,
    output logic                     is_empty,
    output logic                     is_term
);
    localparam int CNT_W = DATA_W - ADDR_W;

    // Field split and classification.
    always_comb begin
        count     = word[DATA_W-1:ADDR_W];
        next_addr = word[ADDR_W-1:0];
        is_empty  = (count == '0);
        is_term   = (next_addr == {ADDR_W{1'b1}});
    end
endmodule

// File: rtl/cmd_chain_buf.sv
// Payload holding register.
// Captures one memory read word on load and holds it for the sink until
// the next load, so the sink sees stable data while it stalls.
module cmd_chain_buf #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    // Capture the fetched payload word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (load)
            dout <= din;
    end
endmodule

// File: rtl/cmd_chain_dma.sv
// Linked command packet DMA walker (top).
// Reads a header at the base address, sends its payload words one by one
// to the sink, and follows the next link until the all-ones terminator.
// Zero-count headers are skipped; after a skip the found header is saved
// in the base register and the engine yields for one cycle before sending.
// Assumes one outstanding memory read; response arrives after acceptance.
module cmd_chain_dma
    import cmd_chain_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] base_addr,
    output logic              busy,
    output logic              done,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              sink_valid,
    output logic [DATA_W-1:0] sink_data,
    input  logic              sink_ready
);
    localparam int                CNT_W = DATA_W - ADDR_W;
    localparam logic [ADDR_W-1:0] TERM  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(4);

    walk_state_t       state_q;
    logic [ADDR_W-1:0] base_q, hdr_q, cur_q, next_q;
    logic [CNT_W-1:0]  rem_q;
    logic              skip_q;

    logic [CNT_W-1:0]  h_count;
    logic [ADDR_W-1:0] h_next;
    logic              h_empty, h_term;

    // Clear the byte-offset bits of an address.
    function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:2], 2'b00};
    endfunction

    cmd_chain_hdr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hdr (
        .word      (mem_rsp_data),
        .count     (h_count),
        .next_addr (h_next),
        .is_empty  (h_empty),
        .is_term   (h_term)
    );

    cmd_chain_buf #(.DATA_W(DATA_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state_q == ST_PAY_WAIT && mem_rsp_valid),
        .din   (mem_rsp_data),
        .dout  (sink_data)
    );

    // Walk sequencer: header fetch, skip/yield, payload streaming, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            hdr_q   <= '0;
            cur_q   <= '0;
            next_q  <= '0;
            rem_q   <= '0;
            skip_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        base_q  <= start_addr;
                        hdr_q   <= word_align(start_addr);
                        skip_q  <= 1'b0;
                        state_q <= ST_HDR_REQ;
                    end
                end
                ST_HDR_REQ: begin
                    if (mem_req_ready)
                        state_q <= ST_HDR_WAIT;
                end
                ST_HDR_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!h_empty) begin
                            if (skip_q) begin
                                base_q  <= hdr_q;
                                state_q <= ST_YIELD;
                            end else begin
                                rem_q   <= h_count;
                                cur_q   <= hdr_q + STEP;
                                next_q  <= h_next;
                                state_q <= ST_PAY_REQ;
                            end
                        end else if (h_term) begin
                            base_q  <= TERM;
                            state_q <= ST_FINISH;
                        end else begin
                            hdr_q   <= word_align(h_next);
                            skip_q  <= 1'b1;
                            state_q <= ST_HDR_REQ;
                        end
                    end
                end
                ST_PAY_REQ: begin
                    if (mem_req_ready)
                        state_q <= ST_PAY_WAIT;
                end
                ST_PAY_WAIT: begin
                    if (mem_rsp_valid)
                        state_q <= ST_PAY_PUSH;
                end
                ST_PAY_PUSH: begin
                    if (sink_ready) begin
                        if (rem_q == CNT_W'(1)) begin
                            base_q  <= next_q;
                            state_q <= (next_q == TERM) ? ST_FINISH : ST_YIELD;
                        end else begin
                            rem_q   <= rem_q - CNT_W'(1);
                            cur_q   <= cur_q + STEP;
                            state_q <= ST_PAY_REQ;
                        end
                    end
                end
                ST_YIELD: begin
                    hdr_q   <= word_align(base_q);
                    skip_q  <= 1'b0;
                    state_q <= ST_HDR_REQ;
                end
                ST_FINISH: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Port outputs decoded from the current state.
    always_comb begin
        base_addr     = base_q;
        mem_req_valid = (state_q == ST_HDR_REQ) || (state_q == ST_PAY_REQ);
        mem_req_addr  = (state_q == ST_HDR_REQ) ? hdr_q : cur_q;
        sink_valid    = (state_q == ST_PAY_PUSH);
        done          = (state_q == ST_FINISH);
        busy          = (state_q != ST_IDLE) && (state_q != ST_FINISH);
    end
endmodule

// File: rtl/cmd_chain_dma_chk.sv
// Protocol checker for the walker, bound to every cmd_chain_dma instance.
// Observes ports only.
module cmd_chain_dma_chk #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] base_addr,
    input logic              busy,
    input logic              done,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_req_ready,
    input logic              sink_valid,
    input logic [DATA_W-1:0] sink_data,
    input logic              sink_ready
);
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done)); // R9
    AST_DONE_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (base_addr == {ADDR_W{1'b1}})); // R5
    AST_SINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sink_valid && !sink_ready) |=> (sink_valid && $stable(sink_data))); // R10
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10
    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00)); // R12
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sink_valid && !mem_req_valid)); // R9
endmodule

bind cmd_chain_dma cmd_chain_dma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .base_addr     (base_addr),
    .busy          (busy),
    .done          (done),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_req_ready (mem_req_ready),
    .sink_valid    (sink_valid),
    .sink_data     (sink_data),
    .sink_ready    (sink_ready)
);

// File: tb/test_cmd_chain_dma.sv
`timescale 1ns/1ps
module test_cmd_chain_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] start_addr = '0;
    logic [23:0] base_addr;
    logic        busy, done;
    logic        mem_req_valid;
    logic [23:0] mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        sink_valid;
    logic [31:0] sink_data;
    logic        sink_ready = 1'b0;

    always #5 clk = ~clk;

    cmd_chain_dma i_cmd_chain_dma (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .base_addr(base_addr), .busy(busy), .done(done),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .sink_valid(sink_valid),
        .sink_data(sink_data), .sink_ready(sink_ready)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int mode    = 0;      // 0: always ready, 1: irregular back-pressure
    logic [31:0] mem [0:255];

    // Observed results of the current walk
    logic [31:0] got_w [0:1023];
    int          got_n = 0;
    logic [23:0] got_b [0:63];
    int          got_bn = 0;
    int          done_cnt = 0;
    logic [23:0] first_req = '0;
    int          req_cnt = 0;
    logic [23:0] last_base = '0;

    // Expected results
    logic [31:0] exp_w [0:1023];
    int          exp_n;
    logic [23:0] exp_b [0:63];
    int          exp_bn;
    logic [23:0] model_base = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory responder: one outstanding read, optional delay and ready gaps.
    initial begin
        logic        pend;
        logic [23:0] paddr;
        int          dly;
        logic [7:0]  lf;
        pend = 1'b0; paddr = '0; dly = 0; lf = 8'h5B;
        forever begin
            @(negedge clk);
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            mem_rsp_valid = 1'b0;
            if (pend && dly == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem[paddr[9:2]];
                pend = 1'b0;
            end else if (pend) begin
                dly--;
            end
            mem_req_ready = (mode == 0) ? 1'b1 : lf[0];
            #1;
            if (mem_req_valid && mem_req_ready) begin
                if (req_cnt == 0) first_req = mem_req_addr;
                req_cnt++;
                pend  = 1'b1;
                paddr = mem_req_addr;
                dly   = (mode == 0) ? 0 : int'(lf[2:1]);
            end
        end
    end

    // Sink: records accepted words under a ready pattern.
    initial begin
        logic [7:0] lf;
        lf = 8'hC3;
        forever begin
            @(negedge clk);
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            sink_ready = (mode == 0) ? 1'b1 : (lf[1] | lf[3]);
            #1;
            if (sink_valid && sink_ready) begin
                if (got_n < 1024) got_w[got_n] = sink_data;
                got_n++;
            end
        end
    end

    // Monitor: base register trace and done pulse shape.
    initial begin
        logic prev_done;
        prev_done = 1'b0;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                if (base_addr != last_base) begin
                    if (got_bn < 64) got_b[got_bn] = base_addr;
                    got_bn++;
                    last_base = base_addr;
                end
                if (done) begin
                    done_cnt++;
                    check(!busy, "R9", "busy low during done", 32'(busy), 0);
                    check(!prev_done, "R9", "done lasts one cycle", 32'(prev_done), 0);
                end
                prev_done = done;
            end
        end
    end

    // Reference walk derived from the requirements.
    task automatic push_base(input logic [23:0] b);
        if (b != model_base) begin
            exp_b[exp_bn] = b;
            exp_bn++;
            model_base = b;
        end
    endtask

    task automatic build_expected(input logic [23:0] sa);
        logic [23:0] b, h, nxt;
        logic [7:0]  cnt;
        logic [31:0] d;
        bit          fin, skipped;
        exp_n = 0; exp_bn = 0;
        push_base(sa);
        b = sa; fin = 0;
        for (int guard = 0; guard < 64 && !fin; guard++) begin
            h = {b[23:2], 2'b00};
            skipped = 0;
            for (int g2 = 0; g2 < 64; g2++) begin
                d = mem[h[9:2]];
                cnt = d[31:24]; nxt = d[23:0];
                if (cnt != 0 && skipped) begin
                    b = h; push_base(b);
                    break;
                end else if (cnt != 0) begin
                    for (int k = 1; k <= int'(cnt); k++) begin
                        exp_w[exp_n] = mem[8'(h[9:2] + k)];
                        exp_n++;
                    end
                    b = nxt; push_base(b);
                    fin = (nxt == 24'hFFFFFF);
                    break;
                end else if (nxt == 24'hFFFFFF) begin
                    b = nxt; push_base(b);
                    fin = 1;
                    break;
                end else begin
                    h = {nxt[23:2], 2'b00};
                    skipped = 1;
                end
            end
        end
    endtask

    task automatic put_hdr(input logic [23:0] a, input logic [7:0] cnt, input logic [23:0] nxt);
        mem[a[9:2]] = {cnt, nxt};
    endtask

    // One complete walk with all port checks; poke != 0 sends a stray start.
    task automatic run_walk(input logic [23:0] sa, input int md, input int poke,
                            input string req);
        logic [23:0] exp_first;
        build_expected(sa);
        mode = md;
        got_n = 0; got_bn = 0; done_cnt = 0; req_cnt = 0;
        exp_first = {sa[23:2], 2'b00};
        @(negedge clk);
        start = 1'b1; start_addr = sa;
        @(negedge clk);
        start = 1'b0;
        #3;
        check(busy == 1'b1, "R9", "busy after start", 32'(busy), 1);
        check(base_addr == sa, "R2", "base loaded", 32'(base_addr), 32'(sa));
        for (int c = 0; c < 20000 && done_cnt == 0; c++) begin
            @(negedge clk);
            if (c == 3 && poke != 0) begin
                start = 1'b1; start_addr = 24'h000080;
                @(negedge clk);
                start = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        #3;
        check(done_cnt == 1, req, "done pulse count", 32'(done_cnt), 1);
        check(!busy, "R9", "idle after walk", 32'(busy), 0);
        check(first_req == exp_first, "R2", "first read address", 32'(first_req), 32'(exp_first));
        check(got_n == exp_n, "R4", "word count", 32'(got_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < got_n; i++)
            check(got_w[i] == exp_w[i], req, "sink word", got_w[i], exp_w[i]);
        check(got_bn == exp_bn, "R5", "base trace length", 32'(got_bn), 32'(exp_bn));
        for (int i = 0; i < exp_bn && i < got_bn; i++)
            check(got_b[i] == exp_b[i], (poke != 0) ? "R11" : "R7", "base trace",
                  32'(got_b[i]), 32'(exp_b[i]));
    endtask

    // Watchdog
    initial begin
        #2000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hA5000000 ^ (i * 32'h00010203);
        // R3 R4 R5: single packet
        put_hdr(24'h010, 8'd3, 24'hFFFFFF);
        // three-packet chain
        put_hdr(24'h020, 8'd2, 24'h000040);
        put_hdr(24'h040, 8'd1, 24'h000060);
        put_hdr(24'h060, 8'd4, 24'hFFFFFF);
        // R6 R7 R8: skips, yield, empty terminator
        put_hdr(24'h080, 8'd0, 24'h000090);
        put_hdr(24'h090, 8'd0, 24'h0000A0);
        put_hdr(24'h0A0, 8'd2, 24'h0000B0);
        put_hdr(24'h0B0, 8'd0, 24'hFFFFFF);
        put_hdr(24'h0C0, 8'd0, 24'hFFFFFF);
        // R3: misaligned link
        put_hdr(24'h100, 8'd1, 24'h000112);
        put_hdr(24'h110, 8'd1, 24'hFFFFFF);

        repeat (3) @(negedge clk);
        #3;
        check(!busy && !done, "R1", "busy/done after reset", {30'd0, busy, done}, 0);
        check(!mem_req_valid && !sink_valid, "R1", "valids after reset",
              {30'd0, mem_req_valid, sink_valid}, 0);
        check(base_addr == 24'h0, "R1", "base after reset", 32'(base_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_walk(24'h010, 0, 0, "R4");
        run_walk(24'h020, 0, 0, "R5");
        run_walk(24'h020, 1, 0, "R10");
        run_walk(24'h080, 0, 0, "R6");
        run_walk(24'h080, 1, 0, "R7");
        run_walk(24'h0C0, 0, 0, "R8");
        run_walk(24'h023, 1, 0, "R2");
        run_walk(24'h100, 0, 0, "R3");
        run_walk(24'h020, 1, 1, "R11");
        // R4 R10 R12: count sweep with and without back-pressure
        for (int n = 1; n <= 40; n++) begin
            put_hdr(24'h200, 8'(n), 24'hFFFFFF);
            run_walk(24'h200, 0, 0, "R4");
            run_walk(24'h200, 1, 0, "R10");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule